// File: doc/BRIEF.md
# Stereo Disparity Search and Depth Mapper

This block turns a pair of row-aligned, already smoothed 8-bit grayscale streams into a depth-map stream. The left stream is the reference. The right stream is the image searched for a match. One pixel of each arrives together on every valid cycle, in raster order. The right pixels are kept in a history window, so the block can see the most recent `MAX_DISP+1` right pixels of the current row. For the incoming left pixel at column x, the block scores every candidate right pixel at column x−d by the absolute intensity difference. The offset with the lowest score is taken as the disparity.

All candidates are scored in the same cycle. A registered binary comparison tree then narrows them to a single winner, one tree level per cycle. On a tie the tree keeps the smaller offset. The winner is converted to a grayscale depth value by subtracting it from full scale, so a near object (large disparity) appears darker within a band just under white. Each accepted input pixel produces exactly one output pixel after a fixed number of cycles. A frame-start marker travels alongside its pixel.

A row-start input resets the column count. Offsets that would reach left of column 0 are never considered, even though the history window still holds pixels from the previous row.

Top module: `stereo_depth_mapper`

## Requirements
- R1: For a left pixel L at column x, the output disparity is the offset d in 0..min(x, MAX_DISP) that minimises |L − R(x−d)|, where R(c) is the right pixel at column c of the same row.
- R2: When two or more offsets share the minimum score, the smallest of those offsets is output.
- R3: The pixel accepted with `in_sol`=1 is column 0, and each later accepted pixel is one column further on. Offsets d greater than the column are excluded, so a column-0 pixel always yields disparity 0.
- R4: The disparity lies in 0..MAX_DISP (default 50), and MAX_DISP itself is reachable.
- R5: `out_depth` = 2^PIX_W − 1 − `out_disp`; with the defaults this is 255 − disparity, so the range is 205..255.
- R6: Each cycle with `in_valid`=1 produces exactly one cycle with `out_valid`=1, LAT = clog2(MAX_DISP+1)+2 cycles later (8 with the defaults). No output appears otherwise.
- R7: `out_sof` is 1 exactly on the output of a pixel accepted with `in_sof`=1.
- R8: During and right after reset, `out_valid` and `out_sof` are 0.
- R9: Cycles with `in_valid`=0 do not move the right-pixel history or the column count, whatever value `in_right` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Left/right pixel pair present |
| in_sof | input | 1 | First pixel of a frame |
| in_sol | input | 1 | First pixel of a row (column 0) |
| in_left | input | PIX_W | Reference (left) intensity |
| in_right | input | PIX_W | Search (right) intensity |
| out_valid | output | 1 | Depth pixel present |
| out_sof | output | 1 | Depth pixel is the first of a frame |
| out_disp | output | 8 | Winning disparity |
| out_depth | output | PIX_W | Depth intensity, full scale minus disparity |

## Verification
The hardest case to reach is the one where the tie rule and the row-start exclusion both matter. A wrong offset must score as well as or better than the correct one: either a later repeat of the same intensity, or a stale pixel from the previous row still held in the window. The bench drives rows whose right image repeats every five columns, rows shifted by the full 50-column range, and rows whose previous row would match better through the stale window. It also inserts idle cycles that carry junk right pixels. Expected disparities come from a brute-force search over the same row in the bench.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

   localparam int SCORE_W = 16;
   localparam int DISP_W  = 8;

   typedef struct packed {
      logic               ok;
      logic [SCORE_W-1:0] score;
      logic [DISP_W-1:0]  disp;
   } cand_t;

   // a is always the lower-offset child, so it keeps ties
   function automatic cand_t pick(input cand_t a, input cand_t b);
      if (!b.ok)               return a;
      if (!a.ok)               return b;
      if (b.score < a.score)   return b;
      return a;
   endfunction

endpackage

// File: rtl/sdm_right_window.sv
module sdm_right_window #(
   parameter int PIX_W    = 8,
   parameter int MAX_DISP = 50,
   parameter int COL_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sol,
   input  logic [PIX_W-1:0] in_right,
   output logic [PIX_W-1:0] tap [MAX_DISP+1],
   output logic [MAX_DISP:0] ok
);
   logic [PIX_W-1:0] hist [MAX_DISP];
   logic [COL_W-1:0] col_q, cur_col;

   assign cur_col = in_sol ? '0 : col_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         col_q <= '0;
      else if (in_valid)
         col_q <= (cur_col == COL_W'(MAX_DISP)) ? cur_col : cur_col + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (in_valid) begin
         hist[0] <= in_right;
         for (int i = 1; i < MAX_DISP; i++) hist[i] <= hist[i-1];
      end
   end

   assign tap[0] = in_right;
   assign ok[0]  = 1'b1;
   for (genvar d = 1; d <= MAX_DISP; d++) begin : g_tap
      assign tap[d] = hist[d-1];
      assign ok[d]  = (COL_W'(d) <= cur_col);
   end
endmodule

// File: rtl/sdm_score_bank.sv
module sdm_score_bank #(
   parameter int PIX_W    = 8,
   parameter int MAX_DISP = 50,
   parameter int LEAVES   = 64
) (
   input  logic             [PIX_W-1:0] in_left,
   input  logic             [PIX_W-1:0] tap [MAX_DISP+1],
   input  logic             [MAX_DISP:0] ok,
   output sdm_pkg::cand_t   leaf [LEAVES]
);
   for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
      if (i <= MAX_DISP) begin : g_real
         logic [PIX_W-1:0] diff;
         assign diff = (in_left >= tap[i]) ? in_left - tap[i] : tap[i] - in_left;
         assign leaf[i].ok    = ok[i];
         assign leaf[i].score = sdm_pkg::SCORE_W'(diff);
         assign leaf[i].disp  = sdm_pkg::DISP_W'(i);
      end else begin : g_pad
         assign leaf[i].ok    = 1'b0;
         assign leaf[i].score = '1;
         assign leaf[i].disp  = '0;
      end
   end
endmodule

// File: rtl/sdm_min_tree.sv
module sdm_min_tree #(
   parameter int LEVELS = 6,
   localparam int LEAVES = 1 << LEVELS
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic           in_sof,
   input  sdm_pkg::cand_t leaf [LEAVES],
   output sdm_pkg::cand_t win,
   output logic           win_valid,
   output logic           win_sof
);
   // heap layout: node 1 is the root, leaves sit at LEAVES..2*LEAVES-1
   sdm_pkg::cand_t node [1:2*LEAVES-1];
   logic [LEVELS:0] vld_sr, sof_sr;

   always_ff @(posedge clk) begin
      for (int i = 0; i < LEAVES; i++) node[LEAVES+i] <= leaf[i];
      for (int k = 1; k < LEAVES; k++) node[k] <= sdm_pkg::pick(node[2*k], node[2*k+1]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_sr <= '0;
         sof_sr <= '0;
      end else begin
         vld_sr <= {vld_sr[LEVELS-1:0], in_valid};
         sof_sr <= {sof_sr[LEVELS-1:0], in_valid & in_sof};
      end
   end

   assign win       = node[1];
   assign win_valid = vld_sr[LEVELS];
   assign win_sof   = sof_sr[LEVELS];
endmodule

// File: rtl/stereo_depth_mapper.sv
module stereo_depth_mapper #(
   parameter int PIX_W    = 8,
   parameter int MAX_DISP = 50
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic                       in_sof,
   input  logic                       in_sol,
   input  logic [PIX_W-1:0]           in_left,
   input  logic [PIX_W-1:0]           in_right,
   output logic                       out_valid,
   output logic                       out_sof,
   output logic [sdm_pkg::DISP_W-1:0] out_disp,
   output logic [PIX_W-1:0]           out_depth
);
   localparam int LEVELS = $clog2(MAX_DISP + 1);
   localparam int LEAVES = 1 << LEVELS;
   localparam int COL_W  = $clog2(MAX_DISP + 1);
   localparam int MAXVAL = (1 << PIX_W) - 1;

   if (MAX_DISP < 1 || MAX_DISP > MAXVAL || MAX_DISP > 255) begin : g_bad_disp
      $error("MAX_DISP must lie in 1..min(255, 2**PIX_W-1)");
   end
   if (PIX_W < 2 || PIX_W > sdm_pkg::SCORE_W) begin : g_bad_pix
      $error("PIX_W must lie in 2..SCORE_W");
   end

   logic [PIX_W-1:0] tap [MAX_DISP+1];
   logic [MAX_DISP:0] ok;
   sdm_pkg::cand_t    leaf [LEAVES];
   sdm_pkg::cand_t    win;
   logic              win_valid, win_sof;

   sdm_right_window #(.PIX_W(PIX_W), .MAX_DISP(MAX_DISP), .COL_W(COL_W)) u_win (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
      .in_right(in_right), .tap(tap), .ok(ok));

   sdm_score_bank #(.PIX_W(PIX_W), .MAX_DISP(MAX_DISP), .LEAVES(LEAVES)) u_score (
      .in_left(in_left), .tap(tap), .ok(ok), .leaf(leaf));

   sdm_min_tree #(.LEVELS(LEVELS)) u_tree (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .leaf(leaf), .win(win), .win_valid(win_valid), .win_sof(win_sof));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
      end else begin
         out_valid <= win_valid;
         out_sof   <= win_sof;
      end
      out_disp  <= win.disp;
      out_depth <= PIX_W'(MAXVAL) - PIX_W'(win.disp);
   end
endmodule

// File: rtl/sdm_checker.sv
module sdm_checker #(
   parameter int PIX_W    = 8,
   parameter int MAX_DISP = 50
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       in_valid,
   input logic                       in_sof,
   input logic                       in_sol,
   input logic                       out_valid,
   input logic                       out_sof,
   input logic [sdm_pkg::DISP_W-1:0] out_disp,
   input logic [PIX_W-1:0]           out_depth
);
   localparam int LAT    = $clog2(MAX_DISP + 1) + 2;
   localparam int MAXVAL = (1 << PIX_W) - 1;

   logic [LAT-1:0] vp, fp, sp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vp <= '0; fp <= '0; sp <= '0;
      end else begin
         vp <= {vp[LAT-2:0], in_valid};
         fp <= {fp[LAT-2:0], in_valid & in_sof};
         sp <= {sp[LAT-2:0], in_valid & in_sol};
      end
   end

   p_valid_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == vp[LAT-1]);
   p_sof_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof == fp[LAT-1]);
   p_first_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sp[LAT-1] |-> out_disp == '0);
   p_disp_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_disp <= sdm_pkg::DISP_W'(MAX_DISP));
   p_depth_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> 32'(out_depth) == MAXVAL - 32'(out_disp));
endmodule

bind stereo_depth_mapper sdm_checker #(.PIX_W(PIX_W), .MAX_DISP(MAX_DISP)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_sol(in_sol),
   .out_valid(out_valid), .out_sof(out_sof), .out_disp(out_disp), .out_depth(out_depth));

// File: tb/tb_stereo_depth_mapper.sv
module tb_stereo_depth_mapper;
   localparam int PIX_W = 8;
   localparam int MAXD  = 50;
   localparam int LAT   = 8;
   localparam int WROW  = 72;

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0;
   logic [7:0] in_left = '0, in_right = '0;
   logic out_valid, out_sof;
   logic [7:0] out_disp, out_depth;

   stereo_depth_mapper #(.PIX_W(PIX_W), .MAX_DISP(MAXD)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_sol(in_sol),
      .in_left(in_left), .in_right(in_right), .out_valid(out_valid), .out_sof(out_sof),
      .out_disp(out_disp), .out_depth(out_depth));

   always #2.5 clk = ~clk;

   int checks = 0, fails = 0;
   longint cyc = 0;
   int q_disp[$], q_sof[$];
   longint q_cyc[$];
   string q_tag[$];
   int rrow [WROW];
   int seen_max = 0;
   string tag = "R1";

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int hsh(input int x, input int s);
      return ((x * 37 + s * 11) ^ ((x >> 2) * 5)) & 255;
   endfunction

   function automatic int absd(input int a, input int b);
      return (a > b) ? a - b : b - a;
   endfunction

   // output monitor, samples one time unit after the edge
   always @(posedge clk) begin
      #1;
      if (rst_n && out_valid) begin
         if (q_disp.size() == 0) begin
            chk(1'b0, "R6", "unexpected output", 1, 0);
         end else begin
            int ed, es;
            longint ec;
            string et;
            ed = q_disp.pop_front(); es = q_sof.pop_front();
            ec = q_cyc.pop_front();  et = q_tag.pop_front();
            chk(int'(out_disp) == ed, et, "disparity", out_disp, ed);
            chk(int'(out_depth) == 255 - ed, "R5", "depth", out_depth, 255 - ed);
            chk(int'(out_sof) == es, "R7", "sof", out_sof, es);
            chk(cyc - ec == LAT, "R6", "latency", cyc - ec, LAT);
            if (ed == MAXD && int'(out_depth) == 205) seen_max++;
         end
      end
   end

   task automatic send(input int l, input int r, input int x, input bit sof, input bit sol);
      int best, bs, s;
      rrow[x] = r;
      best = 0; bs = absd(l, rrow[x]);
      for (int d = 1; d <= MAXD && d <= x; d++) begin
         s = absd(l, rrow[x-d]);
         if (s < bs) begin bs = s; best = d; end
      end
      @(negedge clk);
      in_valid = 1'b1; in_sof = sof; in_sol = sol;
      in_left = 8'(l); in_right = 8'(r);
      q_disp.push_back(best); q_sof.push_back(int'(sof));
      q_cyc.push_back(cyc); q_tag.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0; in_sof = 1'b1; in_sol = 1'b1;
         in_left = 8'(hsh(i, 5)); in_right = 8'(hsh(i, 9)); // junk, must be ignored (R9)
      end
   endtask

   // kind 0: shifted copy by k; 1: flat; 2: period-5 ramp; 3: unrelated
   task automatic row(input int kind, input int k, input bit sof, input int gap, input int seed);
      for (int x = 0; x < WROW; x++) begin
         int r, l;
         case (kind)
            0: begin r = hsh(x, seed); l = (x >= k) ? hsh(x - k, seed) : hsh(x, seed + 99); end
            1: begin r = 100; l = 100; end
            2: begin r = (x % 5) * 40; l = (x >= 3) ? ((x - 3) % 5) * 40 : 7; end
            default: begin r = hsh(x, seed); l = hsh(x, seed + 3); end
         endcase
         send(l, r, x, sof && x == 0, x == 0);
         if (gap > 0 && x % gap == 2) idle(1 + x % 3);
      end
   endtask

   initial begin
      #400000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks + 1);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      chk(out_valid == 1'b0, "R8", "out_valid in reset", out_valid, 0);
      chk(out_sof == 1'b0, "R8", "out_sof in reset", out_sof, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
      tag = "R1";  row(0, 7, 1'b1, 0, 1);
      tag = "R1";  row(0, 0, 1'b0, 0, 2);
      tag = "R4";  row(0, MAXD, 1'b0, 0, 3);
      tag = "R2";  row(1, 0, 1'b0, 0, 0);
      tag = "R2";  row(2, 0, 1'b1, 0, 0);
      tag = "R3";  row(0, 20, 1'b0, 0, 4);
      tag = "R3";  row(3, 0, 1'b0, 0, 4);  // previous row would match through stale window
      tag = "R9";  row(0, 13, 1'b1, 4, 6);
      tag = "R9";  row(3, 0, 1'b0, 5, 7);
      idle(LAT + 4);
      in_valid = 1'b0;
      repeat (4) @(negedge clk);
      chk(seen_max > 0, "R4", "outputs at disparity 50 / depth 205", seen_max, 1);
      chk(q_disp.size() == 0, "R6", "missing outputs", q_disp.size(), 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule